// File: doc/BRIEF.md
# Go-Back-N Link Output Port with Post-Buffer Encoding

This block is the output side of one router port on a link that recovers from errors by go-back-N retransmission. Uncoded flits arrive from the crossbar and are kept in a small circular store. They leave one per cycle onto the link. Each flit gets its check bits on the way out of the store, so the store holds data bits only. A flit that has been sent stays in the store until a fixed round-trip window passes with no negative acknowledgement (NACK). When a NACK arrives, the send point moves back to the oldest flit still held, and every held flit is sent again in its original order.

Three pointers cover the store. The write pointer marks the next free slot. The send pointer marks the next flit to put on the link. The release pointer marks the oldest flit that has not yet been acknowledged. When retransmission is turned off, a slot is freed as soon as its flit is sent, NACK is ignored, and the port is an ordinary FIFO. The check code is even parity over interleaved bit groups. Adjacent data wires fall into different groups, so a fault that flips a pair of neighbouring wires is still caught. The decoder at the far end and the link itself are outside this block.

Top module: `gbn_out_port`

## Requirements
- R1: After reset, link_valid is 0 and wr_ready is 1.
- R2: link_code is {parity, data}: data in bits [DATA_W-1:0], and parity bit g (at position DATA_W+g) is the even parity of every data bit i with i mod NGRP == g.
- R3: Flits leave in the order they were accepted, at most one per cycle. A flit accepted at clock edge k appears with link_valid high after edge k+1 when nothing older is waiting to be sent.
- R4: wr_ready is 0 while DEPTH flits are held. A write offered while wr_ready is 0 is dropped and never appears on the link.
- R5: With retx_en=1, a flit sent at edge s is released at edge s+RTT if nack_in was 0 at edges s+1 through s+RTT. Release frees one slot, and wr_ready reflects the free slot in the next cycle.
- R6: With retx_en=1, nack_in high at an edge stops transmission: link_valid is 0 in the following cycle. From the next edge on, every held flit is sent again, oldest first.
- R7: A NACK that arrives during a replay restarts the replay from the oldest held flit.
- R8: With retx_en=0, nack_in has no effect, a slot is freed at the edge its flit is sent, and the port behaves as a FIFO of depth DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retx_en | input | 1 | 1: go-back-N holding and replay; 0: plain FIFO |
| wr_valid | input | 1 | Crossbar offers a flit |
| wr_data | input | DATA_W | Uncoded flit from the crossbar |
| wr_ready | output | 1 | Store has a free slot; the offered flit is taken at this edge |
| link_valid | output | 1 | link_code carries a flit this cycle |
| link_code | output | DATA_W+NGRP | Coded flit: parity groups above data |
| nack_in | input | 1 | Negative acknowledgement from the receiving end |

## Verification
A flit taken at edge k reaches the link output after edge k+1 at the earliest, because the output stage adds one register. A release at edge s+RTT shows up on wr_ready during the cycle after that edge. A NACK at edge n forces link_valid low for the cycle after n, and the replay starts after edge n+1. A behavioural model in the bench (a queue of held flits with their send stamps) advances on each rising edge from the same inputs. Outputs are compared against it on each falling edge, so every result is checked in the exact cycle it is due.

// File: rtl/gbn_pkg.sv
package gbn_pkg;
  // What the send side does at the coming edge.
  typedef enum logic [1:0] {
    SA_IDLE   = 2'd0,
    SA_SEND   = 2'd1,
    SA_REWIND = 2'd2
  } send_act_e;
endpackage

// File: rtl/gbn_parity_enc.sv
module gbn_parity_enc #(
  parameter int DATA_W = 16,
  parameter int NGRP   = 4,
  parameter int CODE_W = DATA_W + NGRP
) (
  input  logic [DATA_W-1:0] data,
  output logic [CODE_W-1:0] code
);
  // Interleaved groups: bit i belongs to group i mod NGRP.
  function automatic logic [NGRP-1:0] group_parity(input logic [DATA_W-1:0] d);
    logic [NGRP-1:0] p;
    p = '0;
    for (int i = 0; i < DATA_W; i++) begin
      p[i % NGRP] = p[i % NGRP] ^ d[i];
    end
    return p;
  endfunction

  assign code = {group_parity(data), data};
endmodule

// File: rtl/gbn_slot_store.sv
module gbn_slot_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] slots [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) slots[wr_idx] <= wr_data;
  end

  assign rd_data = slots[rd_idx];
endmodule

// File: rtl/gbn_ptr_ctrl.sv
module gbn_ptr_ctrl
  import gbn_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int RTT   = 4,
  parameter int IDX_W = $clog2(DEPTH),
  parameter int PTR_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             retx_en,
  input  logic             nack,
  input  logic             wr_fire,
  output logic [IDX_W-1:0] wr_idx,
  output logic [IDX_W-1:0] snd_idx,
  output logic             full,
  output send_act_e        act
);
  localparam int TMR_W = $clog2(RTT + 1);

  logic [PTR_W-1:0] wr_ptr, snd_ptr, rel_ptr;
  logic [PTR_W-1:0] snd_nxt;
  logic [TMR_W-1:0] tmr [DEPTH];

  // Named internal events.
  logic nack_eff, pending, inflight, snd_fire, rel_fire;
  logic [PTR_W-1:0] occ;

  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
    return p + PTR_W'(1);
  endfunction

  function automatic logic [PTR_W-1:0] ptr_gap(input logic [PTR_W-1:0] ahead,
                                               input logic [PTR_W-1:0] behind);
    return ahead - behind;
  endfunction

  assign occ      = ptr_gap(wr_ptr, rel_ptr);
  assign full     = (occ == PTR_W'(DEPTH));
  assign pending  = (snd_ptr != wr_ptr);
  assign inflight = (snd_ptr != rel_ptr);
  assign nack_eff = nack & retx_en;
  assign snd_fire = pending & ~nack_eff;
  assign rel_fire = retx_en & ~nack_eff & inflight &
                    (tmr[rel_ptr[IDX_W-1:0]] == TMR_W'(1));

  assign wr_idx  = wr_ptr[IDX_W-1:0];
  assign snd_idx = snd_ptr[IDX_W-1:0];

  always_comb begin
    if (nack_eff)      act = SA_REWIND;
    else if (snd_fire) act = SA_SEND;
    else               act = SA_IDLE;
  end

  always_comb begin
    unique case (act)
      SA_REWIND: snd_nxt = rel_ptr;
      SA_SEND:   snd_nxt = ptr_step(snd_ptr);
      default:   snd_nxt = snd_ptr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      snd_ptr <= '0;
      rel_ptr <= '0;
    end else begin
      if (wr_fire) wr_ptr <= ptr_step(wr_ptr);
      snd_ptr <= snd_nxt;
      if (!retx_en)      rel_ptr <= snd_nxt;
      else if (rel_fire) rel_ptr <= ptr_step(rel_ptr);
    end
  end

  // One round-trip countdown per slot, loaded when that slot is sent.
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot_tmr
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tmr[g] <= '0;
      end else if (snd_fire && (snd_idx == IDX_W'(g))) begin
        tmr[g] <= TMR_W'(RTT);
      end else if (tmr[g] != '0) begin
        tmr[g] <= tmr[g] - TMR_W'(1);
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= PTR_W'(DEPTH)); // R4
  AST_SEND_BEHIND_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_gap(snd_ptr, rel_ptr) <= ptr_gap(wr_ptr, rel_ptr)); // R3
  AST_REWIND_TO_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
    nack_eff |=> (snd_ptr == rel_ptr)); // R6
  AST_FIFO_HOLDS_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    !retx_en |=> (rel_ptr == snd_ptr)); // R8
  AST_FULL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    full && !rel_fire && retx_en |=> (wr_ptr == $past(wr_ptr))); // R4
endmodule

// File: rtl/gbn_out_port.sv
module gbn_out_port
  import gbn_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NGRP   = 4,
  parameter int DEPTH  = 4,
  parameter int RTT    = 4,
  parameter int CODE_W = DATA_W + NGRP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              retx_en,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  output logic              link_valid,
  output logic [CODE_W-1:0] link_code,
  input  logic              nack_in
);
  localparam int IDX_W = $clog2(DEPTH);

  logic              full, wr_fire;
  logic [IDX_W-1:0]  wr_idx, snd_idx;
  logic [DATA_W-1:0] rd_data;
  logic [CODE_W-1:0] enc_code;
  send_act_e         act;

  assign wr_ready = ~full;
  assign wr_fire  = wr_valid & ~full;

  gbn_ptr_ctrl #(.DEPTH(DEPTH), .RTT(RTT)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .retx_en (retx_en),
    .nack    (nack_in),
    .wr_fire (wr_fire),
    .wr_idx  (wr_idx),
    .snd_idx (snd_idx),
    .full    (full),
    .act     (act)
  );

  gbn_slot_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .wr_en   (wr_fire),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (snd_idx),
    .rd_data (rd_data)
  );

  gbn_parity_enc #(.DATA_W(DATA_W), .NGRP(NGRP)) u_enc (
    .data (rd_data),
    .code (enc_code)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_valid <= 1'b0;
      link_code  <= '0;
    end else begin
      link_valid <= (act == SA_SEND);
      if (act == SA_SEND) link_code <= enc_code;
    end
  end

  // All parity groups together cover every data bit once, so the whole word has even weight.
  AST_CODE_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    link_valid |-> (^link_code == 1'b0)); // R2
  AST_SILENT_AFTER_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (retx_en && nack_in) |=> !link_valid); // R6
endmodule

// File: tb/tb_gbn_out_port.sv
module tb_gbn_out_port;
  localparam int DATA_W = 16;
  localparam int NGRP   = 4;
  localparam int DEPTH  = 4;
  localparam int RTT    = 4;
  localparam int CODE_W = DATA_W + NGRP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic retx_en = 1'b1;
  logic wr_valid = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic nack_in = 1'b0;
  logic wr_ready, link_valid;
  logic [CODE_W-1:0] link_code;

  always #4 clk = ~clk;

  gbn_out_port #(.DATA_W(DATA_W), .NGRP(NGRP), .DEPTH(DEPTH), .RTT(RTT)) dut (
    .clk(clk), .rst_n(rst_n), .retx_en(retx_en), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_ready(wr_ready), .link_valid(link_valid),
    .link_code(link_code), .nack_in(nack_in)
  );

  int total = 0;
  int bad = 0;
  string tag = "R1";
  bit chk_on = 1'b0;
  bit saw_full = 1'b0;

  // Reference model: held flits in order, count already sent, send stamps.
  logic [DATA_W-1:0] q [$];
  int stamp [$];
  int sent_cnt = 0;
  int cyc = 0;
  bit m_valid = 1'b0;
  logic [CODE_W-1:0] m_code = '0;
  bit m_rdy, m_nk, m_rel, m_snd;

  function automatic logic [CODE_W-1:0] ref_code(input logic [DATA_W-1:0] d);
    logic [NGRP-1:0] p;
    for (int g = 0; g < NGRP; g++) begin
      p[g] = 1'b0;
      for (int i = g; i < DATA_W; i += NGRP) p[g] ^= d[i];
    end
    return {p, d};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); stamp.delete(); sent_cnt = 0; m_valid = 0; cyc = 0;
    end else begin
      m_rdy = (q.size() < DEPTH);
      m_nk  = nack_in && retx_en;
      if (m_nk) begin
        sent_cnt = 0; stamp.delete(); m_valid = 0;
      end else begin
        m_rel = retx_en && (sent_cnt > 0) && (cyc - stamp[0] == RTT);
        m_snd = (sent_cnt < q.size());
        if (m_snd) begin
          m_code = ref_code(q[sent_cnt]);
          m_valid = 1;
          if (retx_en) begin
            stamp.push_back(cyc); sent_cnt++;
          end else begin
            void'(q.pop_front());
          end
        end else begin
          m_valid = 0;
        end
        if (m_rel) begin
          void'(q.pop_front()); void'(stamp.pop_front()); sent_cnt--;
        end
      end
      if (wr_valid && m_rdy) q.push_back(wr_data);
      cyc++;
    end
  end

  task automatic check(input bit ok, input string what, input int got, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && chk_on) begin
      check(link_valid == m_valid, "link_valid", link_valid, m_valid);
      if (m_valid) check(link_code == m_code, "link_code", link_code, m_code);
      check(wr_ready == (q.size() < DEPTH), "wr_ready", wr_ready, q.size() < DEPTH);
      if (!wr_ready) saw_full = 1'b1;
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      bad++; total++;
      $display("FAIL watchdog %s: got cycle %0d expected finish", tag, wd);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step(input bit v, input logic [DATA_W-1:0] d, input bit nk);
    @(negedge clk);
    wr_valid = v; wr_data = d; nack_in = nk;
  endtask

  task automatic go_idle();
    step(0, '0, 0);
    while (q.size() != 0) step(0, '0, 0);
    repeat (3) step(0, '0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    tag = "R1";
    check(link_valid == 1'b0, "reset link_valid", link_valid, 0);
    check(wr_ready == 1'b1, "reset wr_ready", wr_ready, 1);
    chk_on = 1'b1;

    // R2 and R3: spaced and back-to-back flits, distinct bit patterns
    tag = "R3";
    step(1, 16'hA5C3, 0);
    step(0, '0, 0);
    step(1, 16'h0001, 0);
    step(1, 16'h8000, 0);
    step(1, 16'hFFFF, 0);
    tag = "R2";
    go_idle();

    // R4: hold the offer through a full store; dropped writes must not appear
    tag = "R4";
    for (int i = 0; i < 14; i++) step(1, DATA_W'(16'h1100 + i), 0);
    go_idle();
    check(saw_full, "wr_ready seen low", saw_full, 1);

    // R5: release timing after exactly RTT quiet edges
    tag = "R5";
    for (int i = 0; i < 4; i++) step(1, DATA_W'(16'h2200 + i), 0);
    go_idle();

    // R6: NACK mid-flight, replay oldest first
    tag = "R6";
    step(1, 16'h3301, 0);
    step(1, 16'h3302, 0);
    step(1, 16'h3303, 0);
    step(0, '0, 1);
    step(1, 16'h3304, 0);
    go_idle();

    // R7: NACK during a replay restarts it
    tag = "R7";
    for (int i = 0; i < 4; i++) step(1, DATA_W'(16'h4400 + i), 0);
    step(0, '0, 1);
    step(0, '0, 0);
    step(0, '0, 1);
    step(0, '0, 0);
    step(0, '0, 0);
    step(0, '0, 1);
    go_idle();

    // R8: FIFO mode, NACK ignored
    tag = "R8";
    retx_en = 1'b0;
    for (int i = 0; i < 20; i++) step(1, DATA_W'($urandom), (i % 3) == 0);
    go_idle();
    retx_en = 1'b1;
    repeat (2) step(0, '0, 0);

    // Mixed traffic with random NACKs
    tag = "R5";
    for (int i = 0; i < 400; i++)
      step(($urandom % 10) < 6, DATA_W'($urandom), ($urandom % 12) == 0);
    go_idle();

    chk_on = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule